// File: doc/BRIEF.md
# Microprogram Sequencer with Branch Fields

This block steps through a horizontal microprogram held in an internal control store. On every clock it holds a registered microaddress and shows the microword stored there. Logic around the block uses that microword as its control bits. The microaddress that follows is chosen from fields carried by the current microword, not from a step counter. Each word holds two candidate addresses, a primary one and an alternate one. A condition-select field picks which of the two applies: it can name a constant or one of six external flags. Because any word can point anywhere, one instruction can use as many microsteps as it needs, and several instructions can meet in one shared routine, for example an interrupt poll or an operand access.

A dispatch bit in the microword overrides both candidates. The next address then comes from the opcode byte, shifted left so that each opcode owns a small block of entries. The control store is 32 bits wide by default and is built from four byte-wide slices of 2048 entries each. It is filled through a write port while the sequencer is held in reset. The read is combinational from the registered microaddress, so a new microword appears only after a rising clock edge.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high at a rising edge, `uaddr` is set to zero. In the cycle after `rst` falls, `uaddr` is zero and `uword` is the word stored at address zero.
- R2: `uword` always equals the 32-bit word last written to the entry `uaddr` points at. A write stores `load_word` at `load_addr` on a rising edge where `load_en` is high.
- R3: Microword layout: bits [10:0] hold the primary next address, [21:11] the alternate address, [24:22] the condition select and bit 25 the dispatch flag. Bits [31:26] are free control bits and are presented unchanged.
- R4: With dispatch clear and condition select 0, the next `uaddr` is the primary field.
- R5: With dispatch clear and condition select 1, the next `uaddr` is the alternate field.
- R6: With dispatch clear and condition select k in 2..7, the next `uaddr` is the alternate field if `cond_flags[k-2]` is 1 and the primary field otherwise.
- R7: With the dispatch bit set, the next `uaddr` is `opcode` shifted left by 3, kept to 11 bits, whatever the condition select and the flags are.
- R8: No step counter limits the sequence. A chain of 200 words ending in a branch back to its start repeats with a period of exactly 200 cycles.
- R9: `uaddr` and `uword` change only at a rising clock edge. Changing `cond_flags` or `opcode` between edges leaves both unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cond_flags | input | 6 | External condition flags |
| opcode | input | 8 | Opcode byte for dispatch |
| load_en | input | 1 | Control store write enable |
| load_addr | input | 11 | Control store write address |
| load_word | input | 32 | Control store write data |
| uword | output | 32 | Current microword (control bits) |
| uaddr | output | 11 | Current microaddress |

## Verification
The assertions check each next-address rule against the previous cycle's microword, flags and opcode. They assume that `cond_flags` and `opcode` are stable at the rising edge. They also assume the control store is not rewritten while the sequencer runs, because a write would change `uword` under a running sequence. The stimulus meets both assumptions: it changes inputs only near the falling edge and fills the store only while reset is held. A store filled with random words, driven by random flags and opcodes, reaches every condition-select value and the dispatch path many times.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int CSEL_W    = 3;
  localparam int NUM_FLAGS = 6;

  typedef enum logic [1:0] {
    SRC_PRIMARY  = 2'd0,
    SRC_ALTERNATE = 2'd1,
    SRC_DISPATCH = 2'd2
  } nsrc_t;

  localparam logic [CSEL_W-1:0] CSEL_NEVER  = 3'd0;
  localparam logic [CSEL_W-1:0] CSEL_ALWAYS = 3'd1;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int ADDR_W  = 11,
  parameter int WORD_W  = 32,
  parameter int SLICE_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NSLICE = WORD_W / SLICE_W;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    logic [SLICE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en) begin
        mem[wr_addr] <= wr_data[s*SLICE_W +: SLICE_W];
      end
    end

    assign rd_data[s*SLICE_W +: SLICE_W] = mem[rd_addr];
  end
endmodule

// File: rtl/useq_cond.sv
module useq_cond
  import useq_pkg::*;
(
  input  logic [CSEL_W-1:0]    csel,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic                 take_alt
);
  always_comb begin
    take_alt = 1'b0;
    case (csel)
      CSEL_NEVER:  take_alt = 1'b0;
      CSEL_ALWAYS: take_alt = 1'b1;
      default: begin
        for (int i = 0; i < NUM_FLAGS; i++) begin
          if (int'(csel) == i + 2) take_alt = flags[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int OP_W       = 8,
  parameter int DISP_SHIFT = 3
) (
  input  logic [ADDR_W-1:0] primary,
  input  logic [ADDR_W-1:0] alternate,
  input  logic              dispatch,
  input  logic              take_alt,
  input  logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] next_addr,
  output nsrc_t             next_src
);
  localparam int WIDE_W = ADDR_W + OP_W + DISP_SHIFT;

  logic [WIDE_W-1:0] op_wide;
  logic [ADDR_W-1:0] disp_addr;

  assign op_wide   = WIDE_W'(opcode) << DISP_SHIFT;
  assign disp_addr = op_wide[ADDR_W-1:0];

  always_comb begin
    if (dispatch)      next_src = SRC_DISPATCH;
    else if (take_alt) next_src = SRC_ALTERNATE;
    else               next_src = SRC_PRIMARY;
  end

  always_comb begin
    case (next_src)
      SRC_DISPATCH:  next_addr = disp_addr;
      SRC_ALTERNATE: next_addr = alternate;
      default:       next_addr = primary;
    endcase
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int WORD_W     = 32,
  parameter int SLICE_W    = 8,
  parameter int OP_W       = 8,
  parameter int DISP_SHIFT = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] cond_flags,
  input  logic [OP_W-1:0]      opcode,
  input  logic                 load_en,
  input  logic [ADDR_W-1:0]    load_addr,
  input  logic [WORD_W-1:0]    load_word,
  output logic [WORD_W-1:0]    uword,
  output logic [ADDR_W-1:0]    uaddr
);
  localparam int PRI_LSB  = 0;
  localparam int ALT_LSB  = ADDR_W;
  localparam int CSEL_LSB = 2 * ADDR_W;
  localparam int DISP_BIT = CSEL_LSB + CSEL_W;

  if (WORD_W < DISP_BIT + 1) begin : g_bad_width
    $error("microword too narrow for two address fields");
  end

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic [WORD_W-1:0] word;
  logic              take_alt;
  nsrc_t             src;

  useq_store #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .SLICE_W(SLICE_W)
  ) u_store (
    .clk    (clk),
    .wr_en  (load_en),
    .wr_addr(load_addr),
    .wr_data(load_word),
    .rd_addr(addr_q),
    .rd_data(word)
  );

  useq_cond u_cond (
    .csel    (word[CSEL_LSB +: CSEL_W]),
    .flags   (cond_flags),
    .take_alt(take_alt)
  );

  useq_next #(
    .ADDR_W    (ADDR_W),
    .OP_W      (OP_W),
    .DISP_SHIFT(DISP_SHIFT)
  ) u_next (
    .primary  (word[PRI_LSB +: ADDR_W]),
    .alternate(word[ALT_LSB +: ADDR_W]),
    .dispatch (word[DISP_BIT]),
    .take_alt (take_alt),
    .opcode   (opcode),
    .next_addr(addr_d),
    .next_src (src)
  );

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr_d;
  end

  assign uaddr = addr_q;
  assign uword = word;

  logic unused_src;
  assign unused_src = ^src;
endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
  parameter int ADDR_W     = 11,
  parameter int WORD_W     = 32,
  parameter int OP_W       = 8,
  parameter int DISP_SHIFT = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [5:0]        cond_flags,
  input logic [OP_W-1:0]   opcode,
  input logic [WORD_W-1:0] uword,
  input logic [ADDR_W-1:0] uaddr
);
  localparam int WIDE_W = ADDR_W + OP_W + DISP_SHIFT;

  logic [ADDR_W-1:0] f_pri, f_alt, f_disp;
  logic [2:0]        f_csel, f_idx;
  logic              f_dsp, f_hit;
  logic [WIDE_W-1:0] wide;

  assign f_pri  = uword[ADDR_W-1:0];
  assign f_alt  = uword[2*ADDR_W-1:ADDR_W];
  assign f_csel = uword[2*ADDR_W +: 3];
  assign f_dsp  = uword[2*ADDR_W+3];
  assign wide   = WIDE_W'(opcode) << DISP_SHIFT;
  assign f_disp = wide[ADDR_W-1:0];
  assign f_idx  = f_csel - 3'd2;
  assign f_hit  = (f_csel >= 3'd2) && cond_flags[f_idx];

  // R1
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> uaddr == '0);

  // R7
  a_r7_dispatch: assert property (@(posedge clk) disable iff (rst)
    f_dsp |=> uaddr == $past(f_disp));

  // R4
  a_r4_primary_step: assert property (@(posedge clk) disable iff (rst)
    (!f_dsp && f_csel == 3'd0) |=> uaddr == $past(f_pri));

  // R5
  a_r5_forced_alt: assert property (@(posedge clk) disable iff (rst)
    (!f_dsp && f_csel == 3'd1) |=> uaddr == $past(f_alt));

  // R6
  a_r6_flag_taken: assert property (@(posedge clk) disable iff (rst)
    (!f_dsp && f_hit) |=> uaddr == $past(f_alt));

  // R6
  a_r6_flag_clear: assert property (@(posedge clk) disable iff (rst)
    (!f_dsp && f_csel >= 3'd2 && !f_hit) |=> uaddr == $past(f_pri));
endmodule

bind useq_top useq_chk #(
  .ADDR_W    (ADDR_W),
  .WORD_W    (WORD_W),
  .OP_W      (OP_W),
  .DISP_SHIFT(DISP_SHIFT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cond_flags(cond_flags),
  .opcode    (opcode),
  .uword     (uword),
  .uaddr     (uaddr)
);

// File: tb/tb_useq_top.sv
module tb_useq_top;
  localparam int AW = 11;
  localparam int WW = 32;
  localparam int DEPTH = 2048;

  logic          clk = 1'b0;
  logic          rst;
  logic [5:0]    cond_flags;
  logic [7:0]    opcode;
  logic          load_en;
  logic [AW-1:0] load_addr;
  logic [WW-1:0] load_word;
  logic [WW-1:0] uword;
  logic [AW-1:0] uaddr;

  always #4 clk = ~clk;

  useq_top dut (
    .clk(clk), .rst(rst), .cond_flags(cond_flags), .opcode(opcode),
    .load_en(load_en), .load_addr(load_addr), .load_word(load_word),
    .uword(uword), .uaddr(uaddr)
  );

  logic [WW-1:0] ref_mem [DEPTH];
  logic [AW-1:0] m_addr;
  int            m_tag;
  int            n_chk = 0;
  int            n_err = 0;

  // Reference: next address from the requirement rules
  always @(posedge clk) begin
    logic [WW-1:0] w;
    logic [2:0] cs;
    w  = ref_mem[m_addr];
    cs = w[24:22];
    if (rst) begin
      m_addr <= '0; m_tag <= 1;
    end else if (w[25]) begin
      m_addr <= {opcode, 3'b000}; m_tag <= 7;
    end else if (cs == 3'd0) begin
      m_addr <= w[10:0]; m_tag <= 4;
    end else if (cs == 3'd1) begin
      m_addr <= w[21:11]; m_tag <= 5;
    end else begin
      m_addr <= cond_flags[cs - 3'd2] ? w[21:11] : w[10:0]; m_tag <= 6;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string t;
    t = $sformatf("R%0d", m_tag);
    chk(uaddr === m_addr, t, 32'(uaddr), 32'(m_addr));
    chk(uword === ref_mem[m_addr], "R2", uword, ref_mem[m_addr]);
    chk(uword[31:26] === ref_mem[m_addr][31:26], "R3", 32'(uword[31:26]), 32'(ref_mem[m_addr][31:26]));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  function automatic logic [WW-1:0] mkw(input logic [5:0] ctl, input logic dsp,
      input logic [2:0] cs, input logic [AW-1:0] alt, input logic [AW-1:0] pri);
    return {ctl, dsp, cs, alt, pri};
  endfunction

  initial begin
    #(8 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst = 1'b1; cond_flags = '0; opcode = '0;
    load_en = 1'b0; load_addr = '0; load_word = '0;
    // Fill store: 0 -> chain 1..200 looping back to 1 until flag0; rest random
    for (int a = 0; a < DEPTH; a++) begin
      logic [WW-1:0] w;
      if (a == 0)        w = mkw(6'h2A, 1'b0, 3'd0, 11'h7FF, 11'd1);
      else if (a < 200)  w = mkw(6'(a), 1'b0, 3'd0, 11'h7FF, 11'(a + 1));
      else if (a == 200) w = mkw(6'h15, 1'b0, 3'd2, 11'd201, 11'd1);
      else               w = $urandom;
      @(negedge clk);
      load_en = 1'b1; load_addr = 11'(a); load_word = w; ref_mem[a] = w;
    end
    @(negedge clk);
    load_en = 1'b0;
    @(negedge clk);
    chk(uaddr === '0, "R1", 32'(uaddr), 32'd0);
    chk(uword === ref_mem[0], "R2", uword, ref_mem[0]);
    rst = 1'b0;
    // R8: chain run with flags held clear
    for (int k = 0; k <= 450; k++) begin
      if (k > 0) @(negedge clk);
      compare_all();
      if (k == 0)   chk(uword === ref_mem[0], "R1", uword, ref_mem[0]);
      if (k == 150) chk(uaddr === 11'd150, "R8", 32'(uaddr), 32'd150);
      if (k == 201) chk(uaddr === 11'd1, "R8", 32'(uaddr), 32'd1);
      if (k == 401) chk(uaddr === 11'd1, "R8", 32'(uaddr), 32'd1);
    end
    // Random phase covering R4..R7 and R9
    for (int c = 0; c < 3000; c++) begin
      logic [AW-1:0] a0;
      logic [WW-1:0] w0;
      @(negedge clk);
      compare_all();
      rst = (c == 1500 || c == 1501);
      a0 = uaddr; w0 = uword;
      cond_flags = 6'($urandom);
      #1;
      opcode = 8'($urandom);
      cond_flags = 6'($urandom);
      #1;
      chk(uaddr === a0, "R9", 32'(uaddr), 32'(a0));
      chk(uword === w0, "R9", uword, w0);
    end
    @(negedge clk);
    compare_all();
    summary();
  end
endmodule